// File: doc/BRIEF.md
# Unaligned Memory Access Splitter

This block sits between a load/store unit and a 32-bit, byte-addressed memory bus. It accepts one request at a time: an 8-bit, 16-bit or 32-bit operand at any byte address, read or write. A request whose bytes all lie inside one aligned 4-byte word goes out as a single bus cycle. A request whose last byte lands in the following word goes out as two bus cycles, lower word first, and the two halves are joined before the block answers.

Stores are shifted into the byte lanes that the address selects, with a byte enable for each lane written. Loads collect the bytes from one or two bus cycles, put them back in little-endian order and return them zero-extended on a single response pulse. No alignment fault exists: every size is legal at every address.

Top module: `mau_splitter`

## Requirements
- R1: `req_size` encodes the operand width: 0 is 8 bits, 1 is 16 bits, 2 and 3 are both 32 bits.
- R2: A load of N bytes at byte address A returns memory byte A+i in `rsp_data[8i+7:8i]` for i below N, and zeros in the bytes above N.
- R3: A store of N bytes at byte address A writes `req_wdata[8i+7:8i]` to byte A+i for i below N and alters no other byte of memory.
- R4: Every size is accepted at every byte address and each accepted request ends in exactly one `rsp_valid` pulse.
- R5: A request that does not cross a 4-byte boundary uses one bus cycle; `bus_valid` rises the cycle after acceptance and `rsp_valid` is high the cycle after the bus handshake.
- R6: A request that crosses a 4-byte boundary uses two bus cycles; the first has `bus_addr` = A>>2, the second (A>>2)+1 modulo the word-address range.
- R7: `bus_be` bit k is set in a bus cycle exactly when one operand byte has byte address ≡ k (mod 4) within that cycle's word; lane k is `bus_wdata[8k+7:8k]` and `bus_rdata[8k+7:8k]`.
- R8: A load that crosses a boundary returns one response that merges the bytes from both bus cycles.
- R9: The second cycle of a crossing store carries the operand's upper bytes in the low lanes, enabled from lane 0 upward.
- R10: `req_ready` is low from the cycle after acceptance until the response cycle.
- R11: While `bus_valid` is high and `bus_ready` low, `bus_addr`, `bus_be`, `bus_write` and `bus_wdata` hold their values.
- R12: While `rst` is high the block shows `req_ready` = 1, `bus_valid` = 0 and `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | Operand width code |
| req_write | input | 1 | 1 for store, 0 for load |
| req_wdata | input | 32 | Store operand, right-justified |
| bus_valid | output | 1 | Bus cycle presented |
| bus_ready | input | 1 | Bus completes the cycle at this edge |
| bus_addr | output | ADDR_W-2 | Word address of the bus cycle |
| bus_write | output | 1 | Bus cycle direction |
| bus_be | output | 4 | Byte-lane enables |
| bus_wdata | output | 32 | Lane-aligned store data |
| bus_rdata | input | 32 | Read data, valid in the handshake cycle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Load result, zero-extended |

## Verification
The request is registered at acceptance, so the first bus cycle is due one cycle after the accepting edge, and the response one cycle after the last handshake: two cycles after acceptance for a single access and three for a split one when the bus never stalls. The bench steps on falling edges, counts those edges from acceptance, and compares the response position with that count; bus cycles are recorded at the falling edge before the handshake edge, where `bus_valid` and the bench-driven `bus_ready` are both settled. Stalled runs drop the latency comparison and check only the order, contents and steadiness of the bus cycles and the final data.

// File: rtl/mau_pkg.sv
package mau_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        OP_BYTE     = 2'd0,
        OP_HALF     = 2'd1,
        OP_FULL     = 2'd2,
        OP_FULL_ALT = 2'd3
    } op_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [LANES-1:0] be_lo;
        logic [LANES-1:0] be_hi;
        logic             split;
    } lane_plan_t;

    typedef struct packed {
        logic              write;
        op_size_e          size;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] wdata;
    } req_hold_t;

    // Number of operand bytes for a size code.
    function automatic int size_bytes(op_size_e s);
        case (s)
            OP_BYTE: return 1;
            OP_HALF: return 2;
            default: return LANES;
        endcase
    endfunction

    // Right-justified run of ones, one per operand byte.
    function automatic logic [LANES-1:0] size_mask(op_size_e s);
        return LANES'((1 << size_bytes(s)) - 1);
    endfunction

    // Spread the operand mask over two adjacent words.
    function automatic lane_plan_t make_plan(op_size_e s, logic [OFF_W-1:0] off);
        logic [2*LANES-1:0] span;
        lane_plan_t         p;
        span    = {{LANES{1'b0}}, size_mask(s)} << off;
        p.be_lo = span[LANES-1:0];
        p.be_hi = span[2*LANES-1:LANES];
        p.split = |span[2*LANES-1:LANES];
        return p;
    endfunction

endpackage

// File: rtl/mau_lane_plan.sv
module mau_lane_plan
    import mau_pkg::*;
(
    input  op_size_e           size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  wdata,
    output lane_plan_t         plan,
    output logic [DATA_W-1:0]  wdata_lo,
    output logic [DATA_W-1:0]  wdata_hi
);

    logic [DATA_W-1:0]   clean;
    logic [2*DATA_W-1:0] wide;

    // Drop operand bytes above the requested size.
    for (genvar g = 0; g < LANES; g++) begin : g_clean
        assign clean[g*LANE_W +: LANE_W] =
            (g < size_bytes(size)) ? wdata[g*LANE_W +: LANE_W] : '0;
    end

    assign wide     = {{DATA_W{1'b0}}, clean} << (LANE_W * int'(off));
    assign wdata_lo = wide[DATA_W-1:0];
    assign wdata_hi = wide[2*DATA_W-1:DATA_W];
    assign plan     = make_plan(size, off);

endmodule

// File: rtl/mau_load_merge.sv
module mau_load_merge
    import mau_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_lo,
    input  logic               finish,
    input  logic               in_high,
    input  logic               is_load,
    input  op_size_e           size,
    input  logic [OFF_W-1:0]   off,
    input  logic [DATA_W-1:0]  rdata,
    output logic [DATA_W-1:0]  rsp_data
);

    logic [DATA_W-1:0]   lo_q;
    logic [DATA_W-1:0]   lo_src;
    logic [DATA_W-1:0]   hi_src;
    logic [2*DATA_W-1:0] shifted;
    logic [DATA_W-1:0]   merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
        end else if (cap_lo) begin
            lo_q <= rdata;
        end
    end

    assign lo_src  = in_high ? lo_q  : rdata;
    assign hi_src  = in_high ? rdata : '0;
    assign shifted = {hi_src, lo_src} >> (LANE_W * int'(off));

    for (genvar g = 0; g < LANES; g++) begin : g_zext
        assign merged[g*LANE_W +: LANE_W] =
            (g < size_bytes(size)) ? shifted[g*LANE_W +: LANE_W] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_data <= '0;
        end else if (finish) begin
            rsp_data <= is_load ? merged : '0;
        end
    end

endmodule

// File: rtl/mau_seq.sv
module mau_seq
    import mau_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_fire,
    input  logic split,
    input  logic bus_ready,
    output logic bus_valid,
    output logic req_ready,
    output logic in_high,
    output logic cap_lo,
    output logic finish,
    output logic rsp_valid
);

    seq_state_e st_q;
    seq_state_e st_d;

    always_comb begin
        st_d   = st_q;
        cap_lo = 1'b0;
        finish = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_fire) st_d = ST_LOW;
            end
            ST_LOW: begin
                if (bus_ready) begin
                    if (split) begin
                        cap_lo = 1'b1;
                        st_d   = ST_HIGH;
                    end else begin
                        finish = 1'b1;
                        st_d   = ST_IDLE;
                    end
                end
            end
            ST_HIGH: begin
                if (bus_ready) begin
                    finish = 1'b1;
                    st_d   = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            rsp_valid <= 1'b0;
        end else begin
            st_q      <= st_d;
            rsp_valid <= finish;
        end
    end

    assign bus_valid = (st_q != ST_IDLE);
    assign req_ready = (st_q == ST_IDLE);
    assign in_high   = (st_q == ST_HIGH);

endmodule

// File: rtl/mau_splitter.sv
module mau_splitter
    import mau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [1:0]              req_size,
    input  logic                    req_write,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic                    bus_valid,
    input  logic                    bus_ready,
    output logic [ADDR_W-OFF_W-1:0] bus_addr,
    output logic                    bus_write,
    output logic [LANES-1:0]        bus_be,
    output logic [DATA_W-1:0]       bus_wdata,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    rsp_valid,
    output logic [DATA_W-1:0]       rsp_data
);

    localparam int WA_W = ADDR_W - OFF_W;

    req_hold_t         rq_q;
    logic [WA_W-1:0]   wa_q;
    logic              req_fire;
    lane_plan_t        plan;
    logic [DATA_W-1:0] wdata_lo;
    logic [DATA_W-1:0] wdata_hi;
    logic              in_high;
    logic              cap_lo;
    logic              finish;

    assign req_fire = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            rq_q <= '0;
            wa_q <= '0;
        end else if (req_fire) begin
            rq_q.write <= req_write;
            rq_q.size  <= op_size_e'(req_size);
            rq_q.off   <= req_addr[OFF_W-1:0];
            rq_q.wdata <= req_wdata;
            wa_q       <= req_addr[ADDR_W-1:OFF_W];
        end
    end

    mau_lane_plan u_plan (
        .size     (rq_q.size),
        .off      (rq_q.off),
        .wdata    (rq_q.wdata),
        .plan     (plan),
        .wdata_lo (wdata_lo),
        .wdata_hi (wdata_hi)
    );

    mau_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_fire  (req_fire),
        .split     (plan.split),
        .bus_ready (bus_ready),
        .bus_valid (bus_valid),
        .req_ready (req_ready),
        .in_high   (in_high),
        .cap_lo    (cap_lo),
        .finish    (finish),
        .rsp_valid (rsp_valid)
    );

    mau_load_merge u_merge (
        .clk      (clk),
        .rst      (rst),
        .cap_lo   (cap_lo),
        .finish   (finish),
        .in_high  (in_high),
        .is_load  (!rq_q.write),
        .size     (rq_q.size),
        .off      (rq_q.off),
        .rdata    (bus_rdata),
        .rsp_data (rsp_data)
    );

    assign bus_addr  = in_high ? (wa_q + WA_W'(1)) : wa_q;
    assign bus_be    = in_high ? plan.be_hi : plan.be_lo;
    assign bus_wdata = in_high ? wdata_hi : wdata_lo;
    assign bus_write = rq_q.write;

endmodule

// File: rtl/mau_splitter_chk.sv
module mau_splitter_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-3:0] bus_addr,
    input logic              bus_write,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic              rsp_valid
);

    // R12: first cycle out of reset shows the idle face
    a_r12_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !bus_valid && !rsp_valid));

    // R10: no request taken while a bus cycle is outstanding
    a_r10_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> !req_ready);

    // R11: a stalled bus cycle holds still
    a_r11_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
            $stable(bus_be) && $stable(bus_write) && $stable(bus_wdata)));

    // R7: every bus cycle enables at least one lane
    a_r7_some_lane: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (bus_be != 4'b0000));

    // R1: a byte request enables exactly one lane
    a_r1_byte_one_lane: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_size == 2'd0) |=> (bus_valid && $onehot(bus_be)));

    // R5: aligned 32-bit access is one full-width cycle
    a_r5_aligned_full: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_size[1] && req_addr[1:0] == 2'b00)
            |=> (bus_valid && bus_be == 4'b1111));

    // R4: a response is a single-cycle pulse
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

bind mau_splitter mau_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_write (bus_write),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rsp_valid (rsp_valid)
);

// File: tb/mau_splitter_tb.sv
module mau_splitter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic        bus_ready = 1'b0;
    logic [29:0] bus_addr;
    logic        bus_write;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int nchk  = 0;
    int nfail = 0;

    logic [7:0] bmem [64];
    logic [7:0] rmem [64];

    always #10 clk = ~clk;

    mau_splitter #(.ADDR_W(32)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    logic [5:0] rbase;
    always_comb begin
        rbase     = {bus_addr[3:0], 2'b00};
        bus_rdata = {bmem[rbase + 6'd3], bmem[rbase + 6'd2], bmem[rbase + 6'd1], bmem[rbase]};
    end

    // {write, size, addr[7:0], bus cycles, wdata}
    localparam int NV = 18;
    localparam logic [44:0] VEC [NV] = '{
        {1'b1, 2'd2, 8'h00, 2'd1, 32'h11223344},
        {1'b0, 2'd2, 8'h00, 2'd1, 32'h0},
        {1'b1, 2'd1, 8'h06, 2'd1, 32'h5555A5B6},
        {1'b0, 2'd1, 8'h06, 2'd1, 32'h0},
        {1'b1, 2'd1, 8'h07, 2'd2, 32'h7777C3D4},
        {1'b0, 2'd1, 8'h07, 2'd2, 32'h0},
        {1'b1, 2'd2, 8'h0D, 2'd2, 32'h99887766},
        {1'b0, 2'd2, 8'h0D, 2'd2, 32'h0},
        {1'b1, 2'd2, 8'h12, 2'd2, 32'hCAFEF00D},
        {1'b0, 2'd2, 8'h12, 2'd2, 32'h0},
        {1'b1, 2'd2, 8'h1B, 2'd2, 32'h0BADBEEF},
        {1'b0, 2'd2, 8'h1B, 2'd2, 32'h0},
        {1'b1, 2'd0, 8'h21, 2'd1, 32'hFFFFFF5A},
        {1'b0, 2'd0, 8'h23, 2'd1, 32'h0},
        {1'b0, 2'd1, 8'h05, 2'd1, 32'h0},
        {1'b0, 2'd3, 8'h2C, 2'd1, 32'h0},   // R1: code 3 is 32 bits
        {1'b1, 2'd1, 8'h2F, 2'd2, 32'hEEEE1234},
        {1'b0, 2'd2, 8'h2E, 2'd2, 32'h0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_req(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                           input logic [31:0] wd, input int exp_n, input int stall);
        int          nb;
        logic [29:0] ewa [2];
        logic [3:0]  ebe [2];
        logic [29:0] hwa [2];
        logic [3:0]  hbe [2];
        int          calc_n;
        int          k;
        int          nh;
        int          wcnt;
        int          lat;
        bit          got;
        bit          busy_bad;
        logic [31:0] rdat;
        logic [31:0] expd;
        bit          mem_ok;
        string       dtag;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        for (int c = 0; c < 2; c++) begin
            ewa[c] = addr[31:2] + 30'(c);
            ebe[c] = 4'b0000;
            hwa[c] = '0;
            hbe[c] = '0;
            for (int i = 0; i < nb; i++) begin
                logic [31:0] b;
                b = addr + 32'(i);
                if (b[31:2] == ewa[c]) ebe[c][b[1:0]] = 1'b1;
            end
        end
        calc_n = (ebe[1] != 4'b0000) ? 2 : 1;
        if (sz == 2'd3) dtag = "R1";
        else if (calc_n == 2) dtag = wr ? "R9" : "R8";
        else dtag = wr ? "R3" : "R2";

        @(negedge clk);
        check(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
        k = 0; nh = 0; wcnt = 0; lat = 0; got = 1'b0; busy_bad = 1'b0; rdat = '0;
        while (!got && k < 200) begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            if (rsp_valid) begin
                got = 1'b1; lat = k; rdat = rsp_data;
            end else if (req_ready) begin
                busy_bad = 1'b1;
            end
            if (bus_valid) begin
                if (wcnt < stall) begin
                    bus_ready = 1'b0; wcnt++;
                end else begin
                    bus_ready = 1'b1; wcnt = 0;
                    if (nh < 2) begin hwa[nh] = bus_addr; hbe[nh] = bus_be; end
                    nh++;
                    if (bus_write) begin
                        for (int l = 0; l < 4; l++)
                            if (bus_be[l]) bmem[{bus_addr[3:0], 2'(l)}] = bus_wdata[l*8 +: 8];
                    end
                end
            end else begin
                bus_ready = 1'b0;
            end
        end
        bus_ready = 1'b0;

        check(got, "R4 response seen", 32'(got), 32'd1);
        check(!busy_bad, "R10 ready low while busy", 32'(busy_bad), 32'd0);
        check(nh == exp_n && nh == calc_n, "R6 bus cycle count", 32'(nh), 32'(calc_n));
        for (int c = 0; c < 2; c++) begin
            if (c < calc_n) begin
                check(hwa[c] == ewa[c], (stall > 0) ? "R11 word address" : "R6 word address",
                      32'(hwa[c]), 32'(ewa[c]));
                check(hbe[c] == ebe[c], "R7 byte enables", 32'(hbe[c]), 32'(ebe[c]));
            end
        end
        if (stall == 0)
            check(lat == calc_n + 1, "R5 response latency", 32'(lat), 32'(calc_n + 1));

        if (wr) begin
            for (int i = 0; i < nb; i++) rmem[6'(addr + 32'(i))] = wd[i*8 +: 8];
            mem_ok = 1'b1;
            for (int i = 0; i < 64; i++) if (bmem[i] != rmem[i]) mem_ok = 1'b0;
            check(mem_ok, {dtag, " store memory image"}, 32'(mem_ok), 32'd1);
        end else begin
            expd = '0;
            for (int i = 0; i < nb; i++) expd[i*8 +: 8] = rmem[6'(addr + 32'(i))];
            check(rdat == expd, {dtag, " load data"}, rdat, expd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R4 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 8'(i * 7 + 3);
            rmem[i] = 8'(i * 7 + 3);
        end
        // R12: reset state
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready in reset", 32'(req_ready), 32'd1);
        check(bus_valid == 1'b0, "R12 bus idle in reset", 32'(bus_valid), 32'd0);
        check(rsp_valid == 1'b0, "R12 no response in reset", 32'(rsp_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [44:0] e;
            e = VEC[v];
            run_req(e[44], e[43:42], {24'h0, e[41:34]}, e[31:0], int'(e[33:32]), 0);
        end

        // R6: word address wraps at the top of the space
        run_req(1'b1, 2'd2, 32'hFFFFFFFE, 32'hA1B2C3D4, 2, 0);
        run_req(1'b0, 2'd2, 32'hFFFFFFFE, 32'h0, 2, 0);
        run_req(1'b0, 2'd1, 32'hFFFFFFFF, 32'h0, 2, 0);

        // R11: stalled bus on split accesses
        run_req(1'b1, 2'd2, 32'h00000035, 32'h13579BDF, 2, 2);
        run_req(1'b0, 2'd2, 32'h00000035, 32'h0, 2, 3);
        run_req(1'b0, 2'd0, 32'h00000037, 32'h0, 1, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule